// File: doc/BRIEF.md
# Time-Sliced Multi-Channel DMA Controller

This block moves 128-bit quadwords from a main-memory read port to a set of device channels. Each channel has its own sink handshake. A channel is programmed with a byte address and a quadword count, then started. Memory is read directly, with no cache in the path. The controller runs on its own and has no stall path toward a processor.

Channels with work share the memory port. Each channel in turn gets a slice of up to eight memory slots, in ascending channel order, and the rotation wraps. A channel can also run a linked list. In that mode it reads a tag quadword that names the next block of data, states how long that block is, and says whether the list goes on.

Each channel has a sticky done flag and a one-cycle interrupt pulse. Both are raised when the channel's work completes.

Top module: `dmaslc_top`

## Requirements
- R1: After reset no sink valid is high, no memory read is issued, and every done flag is low.
- R2: Configuration writes use these select codes: 0 for the byte address, 1 for the count, 2 to start a plain transfer. A plain transfer with count N delivers N quadwords, read from the address, the address plus 16, and so on, in that order. They go only to the sink of the channel that was started. At most one sink valid is high in any cycle.
- R3: Memory is read only at 16-byte aligned addresses. Bits [3:0] of a programmed address, and of a tag address, are ignored.
- R4: Busy channels take turns in ascending channel order, wrapping from the highest back to channel 0. Each turn lasts eight memory slots. A slot is an accepted data quadword or a tag fetch.
- R5: A turn ends early on the slot that completes a channel's work. In that case the next busy channel is served from the very next cycle.
- R6: While a sink holds ready low, its valid and the memory address stay steady. That channel keeps the port until its turn has used all eight slots.
- R7: Select code 3 starts a linked list at the programmed address. Each tag has these fields: count in bits [15:0], kind in bits [30:28], address in bits [63:32], side data in bits [95:64]. Kind 3: the data block is at the tag address, and the next tag follows this tag. Kind 2: the data block follows this tag, and the next tag is at the tag address. Any other kind ends the list after the data block that follows the tag. A tag fetch uses one slot. The side data appears on the side output while that tag's data is delivered.
- R8: On the cycle after the last quadword is accepted, the channel's irq is high for one cycle and its done flag is set. Done stays high until the next start of that channel.
- R9: A plain start with count 0 transfers nothing. It raises irq and done on the next cycle.
- R10: A start written to a busy channel is ignored. The running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel addressed by the write |
| cfg_sel | input | 2 | 0 address, 1 count, 2 plain start, 3 list start |
| cfg_data | input | 32 | Write data |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 32 | Quadword-aligned byte address |
| mem_rdata | input | 128 | Read data, valid in the same cycle |
| snk_valid | output | NCH | Per-channel data valid |
| snk_ready | input | NCH | Per-channel sink ready |
| snk_data | output | 128 | Quadword for the channel whose valid is high |
| snk_side | output | 32 | Tag side data for the served channel |
| done | output | NCH | Sticky completion flags |
| irq | output | NCH | One-cycle completion pulses |

## Verification
The bench uses the default build: four channels and an eight-slot turn. With four channels, a three-channel mix shows wrap-around and early turn ends. A transfer of 20 quadwords spans three turns, so both the full and the partial turns appear. Toggling one sink's ready, while a second channel waits, shows whether a stalled channel keeps its turn. A three-tag list exercises every tag kind, along with the side data and the point where the tag address is used.

// File: rtl/dmaslc_pkg.sv
package dmaslc_pkg;
  localparam int QW   = 128;
  localparam int AW   = 32;
  localparam int CNTW = 16;
  localparam int SDW  = 32;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_CNT   = 2'd1,
    SEL_GO    = 2'd2,
    SEL_CHAIN = 2'd3
  } cfg_sel_e;

  typedef enum logic [2:0] {
    TG_END  = 3'd0,
    TG_NEXT = 3'd2,
    TG_REF  = 3'd3
  } tag_kind_e;

  typedef struct packed {
    logic [SDW-1:0]  side;
    logic [AW-1:0]   addr;
    logic [2:0]      kind;
    logic [CNTW-1:0] cnt;
  } tag_t;

  // drop the byte offset inside a quadword
  function automatic logic [AW-1:0] qw_align(input logic [AW-1:0] a);
    return {a[AW-1:4], 4'h0};
  endfunction

  function automatic logic [AW-1:0] qw_step(input logic [AW-1:0] a);
    return a + AW'(16);
  endfunction

  function automatic tag_t tag_decode(input logic [QW-1:0] q);
    tag_t t;
    t.side = q[95:64];
    t.addr = qw_align(q[63:32]);
    t.kind = q[30:28];
    t.cnt  = q[15:0];
    return t;
  endfunction

  // where the data block of a tag lives
  function automatic logic [AW-1:0] blk_addr(input tag_t t, input logic [AW-1:0] tp);
    return (t.kind == TG_REF) ? t.addr : qw_step(tp);
  endfunction

  // where the following tag lives
  function automatic logic [AW-1:0] link_addr(input tag_t t, input logic [AW-1:0] tp);
    return (t.kind == TG_NEXT) ? t.addr : qw_step(tp);
  endfunction

  function automatic logic tag_is_last(input tag_t t);
    return !(t.kind == TG_NEXT || t.kind == TG_REF);
  endfunction
endpackage

// File: rtl/dmaslc_arb.sv
module dmaslc_arb #(
  parameter int NCH   = 4,
  parameter int SLICE = 8,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW   = (SLICE > 1) ? $clog2(SLICE) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] busy,
  input  logic           beat,
  input  logic           fin,
  output logic [CHW-1:0] cur
);
  logic [SW-1:0]  slot;
  logic [NCH-1:0] others;
  logic           slice_end;

  // nearest set bit after c, wrapping; c itself last; c when none
  function automatic logic [CHW-1:0] pick_after(input logic [CHW-1:0] c,
                                                 input logic [NCH-1:0] m);
    logic [CHW-1:0] r;
    int idx;
    r = c;
    for (int k = NCH; k >= 1; k--) begin
      idx = (int'(c) + k) % NCH;
      if (m[idx]) r = CHW'(idx);
    end
    return r;
  endfunction

  assign others    = busy & ~(NCH'(1) << cur);
  assign slice_end = beat && (fin || slot == SW'(SLICE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur  <= '0;
      slot <= '0;
    end else if (!busy[cur]) begin
      cur  <= pick_after(cur, busy);
      slot <= '0;
    end else if (slice_end) begin
      cur  <= pick_after(cur, fin ? others : busy);
      slot <= '0;
    end else if (beat) begin
      slot <= slot + SW'(1);
    end
  end

  // R6: a served channel without an accepted slot keeps the port
  a_r6_stall_keeps_turn: assert property (@(posedge clk) disable iff (!rst_n)
    busy[cur] && !beat |=> cur == $past(cur));

  // R5: after a completing slot another busy channel is served at once
  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    beat && fin && (|others) |=> busy[cur]);
endmodule

// File: rtl/dmaslc_chan.sv
module dmaslc_chan
  import dmaslc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [AW-1:0]  wr_data,
  input  logic           gnt,
  input  logic           snk_ready,
  input  logic [QW-1:0]  mem_rdata,
  output logic           busy,
  output logic [AW-1:0]  rd_addr,
  output logic           want_sink,
  output logic [SDW-1:0] side,
  output logic           beat,
  output logic           fin,
  output logic           done,
  output logic           irq
);
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_TAG, ST_CDATA} st_e;

  st_e             st;
  logic [AW-1:0]   prog_addr, ptr, tag_ptr;
  logic [CNTW-1:0] prog_cnt, rem;
  logic            last_blk;
  tag_t            tg;
  logic            go_wr, start_plain, start_list, zero_go, data_last;

  assign tg          = tag_decode(mem_rdata);
  assign busy        = (st != ST_IDLE);
  assign want_sink   = gnt && (st == ST_DATA || st == ST_CDATA);
  assign rd_addr     = (st == ST_TAG) ? tag_ptr : ptr;
  assign beat        = gnt && ((st == ST_TAG) || (want_sink && snk_ready));
  assign go_wr       = wr_en && (wr_sel == SEL_GO) && !busy;
  assign start_plain = go_wr && (prog_cnt != '0);
  assign zero_go     = go_wr && (prog_cnt == '0);
  assign start_list  = wr_en && (wr_sel == SEL_CHAIN) && !busy;
  assign data_last   = beat && (st != ST_TAG) && (rem == CNTW'(1));
  assign fin         = (data_last && (st == ST_DATA || last_blk)) ||
                       (beat && st == ST_TAG && tg.cnt == '0 && tag_is_last(tg));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      prog_addr <= '0;
      prog_cnt  <= '0;
      ptr       <= '0;
      tag_ptr   <= '0;
      rem       <= '0;
      last_blk  <= 1'b0;
      side      <= '0;
      done      <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= fin || zero_go;
      if (wr_en && wr_sel == SEL_ADDR) prog_addr <= wr_data;
      if (wr_en && wr_sel == SEL_CNT)  prog_cnt  <= wr_data[CNTW-1:0];
      if (fin || zero_go)                done <= 1'b1;
      else if (start_plain || start_list) done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_plain) begin
            ptr  <= qw_align(prog_addr);
            rem  <= prog_cnt;
            side <= '0;
            st   <= ST_DATA;
          end else if (start_list) begin
            tag_ptr <= qw_align(prog_addr);
            st      <= ST_TAG;
          end
        end
        ST_DATA: if (beat) begin
          ptr <= qw_step(ptr);
          rem <= rem - CNTW'(1);
          if (data_last) st <= ST_IDLE;
        end
        ST_TAG: if (beat) begin
          side     <= tg.side;
          ptr      <= blk_addr(tg, tag_ptr);
          tag_ptr  <= link_addr(tg, tag_ptr);
          rem      <= tg.cnt;
          last_blk <= tag_is_last(tg);
          if (tg.cnt != '0)          st <= ST_CDATA;
          else if (tag_is_last(tg))  st <= ST_IDLE;
        end
        ST_CDATA: if (beat) begin
          ptr <= qw_step(ptr);
          rem <= rem - CNTW'(1);
          if (data_last) st <= last_blk ? ST_IDLE : ST_TAG;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6: a refused quadword stays offered at the same address
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    want_sink && !snk_ready |=> want_sink && $stable(rd_addr));

  // R8: a raised done flag means the channel has no work left
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: the pulse only comes with the flag
  a_r8_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
endmodule

// File: rtl/dmaslc_top.sv
module dmaslc_top
  import dmaslc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SLICE = 8,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_data,
  output logic           mem_rd,
  output logic [AW-1:0]  mem_addr,
  input  logic [QW-1:0]  mem_rdata,
  output logic [NCH-1:0] snk_valid,
  input  logic [NCH-1:0] snk_ready,
  output logic [QW-1:0]  snk_data,
  output logic [SDW-1:0] snk_side,
  output logic [NCH-1:0] done,
  output logic [NCH-1:0] irq
);
  logic [NCH-1:0] busy_v, beat_v, fin_v, want_v;
  logic [AW-1:0]  rd_addr_a [NCH];
  logic [SDW-1:0] side_a    [NCH];
  logic [CHW-1:0] cur;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmaslc_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we && cfg_ch == CHW'(g)),
      .wr_sel    (cfg_sel),
      .wr_data   (cfg_data),
      .gnt       (cur == CHW'(g)),
      .snk_ready (snk_ready[g]),
      .mem_rdata (mem_rdata),
      .busy      (busy_v[g]),
      .rd_addr   (rd_addr_a[g]),
      .want_sink (want_v[g]),
      .side      (side_a[g]),
      .beat      (beat_v[g]),
      .fin       (fin_v[g]),
      .done      (done[g]),
      .irq       (irq[g])
    );
  end

  dmaslc_arb #(.NCH(NCH), .SLICE(SLICE)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy_v),
    .beat  (beat_v[cur]),
    .fin   (fin_v[cur]),
    .cur   (cur)
  );

  assign mem_rd    = busy_v[cur];
  assign mem_addr  = rd_addr_a[cur];
  assign snk_valid = want_v;
  assign snk_data  = mem_rdata;
  assign snk_side  = side_a[cur];

  // R2: only one sink is offered data at a time
  a_r2_one_sink: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(snk_valid));

  // R3: reads land on quadword boundaries
  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr[3:0] == 4'h0);
endmodule

// File: tb/dmaslc_top_test.sv
`timescale 1ns/1ps
module dmaslc_top_test;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           cfg_we = 1'b0;
  logic [1:0]     cfg_ch = '0;
  logic [1:0]     cfg_sel = '0;
  logic [31:0]    cfg_data = '0;
  logic           mem_rd;
  logic [31:0]    mem_addr;
  logic [127:0]   mem_rdata;
  logic [NCH-1:0] snk_valid, done, irq;
  logic [NCH-1:0] rdy = '1;
  logic [127:0]   snk_data;
  logic [31:0]    snk_side;

  int n_cmp = 0;
  int n_bad = 0;
  logic [160:0]   exp_q [NCH][$];
  int             seq [$];
  int             eseq [$];
  logic [NCH-1:0] irq_pend = '0;
  string          cur_req = "R2";
  logic [160:0]   e;

  dmaslc_top #(.NCH(NCH), .SLICE(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .snk_valid(snk_valid), .snk_ready(rdy), .snk_data(snk_data), .snk_side(snk_side),
    .done(done), .irq(irq)
  );

  function automatic logic [127:0] pat(input logic [31:0] a);
    return {a ^ 32'hC3C3_0000, ~a, a + 32'h0101_0101, a};
  endfunction

  function automatic logic [127:0] mk_tag(input logic [31:0] sd, input logic [31:0] ad,
                                          input logic [2:0] kd, input logic [15:0] n);
    return {32'h0, sd, ad, 1'b0, kd, 12'h0, n};
  endfunction

  // memory: three list tags, pattern data everywhere else
  always_comb begin
    case (mem_addr)
      32'h1000: mem_rdata = mk_tag(32'hAAAA_0001, 32'h1100, 3'd2, 16'd2);
      32'h1100: mem_rdata = mk_tag(32'hBBBB_0002, 32'h2000, 3'd3, 16'd3);
      32'h1110: mem_rdata = mk_tag(32'hCCCC_0003, 32'h0, 3'd0, 16'd1);
      default:  mem_rdata = pat(mem_addr);
    endcase
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [159:0] act, input logic [159:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic push_one(input int ch, input bit last, input logic [31:0] sd,
                          input logic [31:0] a);
    exp_q[ch].push_back({last, sd, pat(a)});
  endtask

  task automatic push_plain(input int ch, input logic [31:0] a, input int n);
    logic [31:0] base = {a[31:4], 4'h0};
    for (int i = 0; i < n; i++) push_one(ch, i == n - 1, 32'h0, base + 32'(16 * i));
  endtask

  task automatic cfg_wr(input int ch, input int sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_data = d;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic exp_run(input int ch, input int n);
    repeat (n) eseq.push_back(ch);
  endtask

  task automatic chk_order(input string req);
    bit ok = (seq.size() == eseq.size());
    if (ok) foreach (seq[i]) if (seq[i] != eseq[i]) ok = 1'b0;
    chk(ok, req, "service order", 160'(seq.size()), 160'(eseq.size()));
  endtask

  task automatic drain();
    while (exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size() != 0
           || irq_pend != '0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  // monitor: compare every accepted quadword against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) if (irq_pend[c]) begin
        irq_pend[c] = 1'b0;
        chk(irq[c] && done[c], "R8", "irq and done after final beat",
            {158'b0, irq[c], done[c]}, 160'd3);
      end
      for (int c = 0; c < NCH; c++) if (snk_valid[c] && rdy[c]) begin
        seq.push_back(c);
        if (exp_q[c].size() == 0) begin
          chk(1'b0, cur_req, "beat with nothing expected", {snk_side, snk_data}, '0);
        end else begin
          e = exp_q[c].pop_front();
          chk({snk_side, snk_data} == e[159:0], cur_req, "quadword",
              {snk_side, snk_data}, e[159:0]);
          if (e[160]) irq_pend[c] = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(snk_valid == '0 && !mem_rd && done == '0, "R1", "reset state",
        {155'b0, mem_rd, snk_valid}, '0);
    @(posedge clk); #1;

    // R2 plain transfer on channel 0
    cur_req = "R2";
    push_plain(0, 32'h100, 10);
    cfg_wr(0, 0, 32'h100); cfg_wr(0, 1, 10); cfg_wr(0, 2, 0);
    drain();
    chk(done == 4'b0001, "R8", "done flag stays set", 160'(done), 160'd1);

    // R4 two channels rotate in eight-slot turns
    cur_req = "R4";
    push_plain(0, 32'h4000, 20); push_plain(1, 32'h8000, 20);
    cfg_wr(0, 0, 32'h4000); cfg_wr(0, 1, 20);
    cfg_wr(1, 0, 32'h8000); cfg_wr(1, 1, 20);
    seq.delete(); eseq.delete();
    cfg_wr(0, 2, 0); cfg_wr(1, 2, 0);
    drain();
    exp_run(0, 8); exp_run(1, 8); exp_run(0, 8); exp_run(1, 8); exp_run(0, 4); exp_run(1, 4);
    chk_order("R4");

    // R5 early turn end with three channels
    cur_req = "R5";
    push_plain(0, 32'hA000, 20); push_plain(1, 32'hB000, 3); push_plain(2, 32'hC000, 12);
    cfg_wr(0, 0, 32'hA000); cfg_wr(0, 1, 20);
    cfg_wr(1, 0, 32'hB000); cfg_wr(1, 1, 3);
    cfg_wr(2, 0, 32'hC000); cfg_wr(2, 1, 12);
    seq.delete(); eseq.delete();
    cfg_wr(0, 2, 0); cfg_wr(1, 2, 0); cfg_wr(2, 2, 0);
    drain();
    exp_run(0, 8); exp_run(1, 3); exp_run(2, 8); exp_run(0, 8); exp_run(2, 4); exp_run(0, 4);
    chk_order("R5");

    // R7 linked list on channel 1: next, ref, end
    cur_req = "R7";
    push_one(1, 1'b0, 32'hAAAA_0001, 32'h1010);
    push_one(1, 1'b0, 32'hAAAA_0001, 32'h1020);
    push_one(1, 1'b0, 32'hBBBB_0002, 32'h2000);
    push_one(1, 1'b0, 32'hBBBB_0002, 32'h2010);
    push_one(1, 1'b0, 32'hBBBB_0002, 32'h2020);
    push_one(1, 1'b1, 32'hCCCC_0003, 32'h1120);
    cfg_wr(1, 0, 32'h1000); cfg_wr(1, 3, 0);
    @(negedge clk);
    chk(done[1] == 1'b0, "R8", "done cleared by start", 160'(done[1]), '0);
    drain();

    // R6 stalled sink keeps its turn
    cur_req = "R6";
    push_plain(2, 32'h5000, 6); push_plain(3, 32'h6000, 12);
    cfg_wr(2, 0, 32'h5000); cfg_wr(2, 1, 6);
    cfg_wr(3, 0, 32'h6000); cfg_wr(3, 1, 12);
    seq.delete(); eseq.delete();
    rdy[2] = 1'b0;
    cfg_wr(2, 2, 0); cfg_wr(3, 2, 0);
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #1 rdy[2] = ~rdy[2];
    end
    rdy[2] = 1'b1;
    drain();
    exp_run(2, 6); exp_run(3, 12);
    chk_order("R6");

    // R3 unaligned start address
    cur_req = "R3";
    push_plain(3, 32'h300B, 2);
    cfg_wr(3, 0, 32'h300B); cfg_wr(3, 1, 2); cfg_wr(3, 2, 0);
    drain();

    // R10 start on a busy channel is ignored
    cur_req = "R10";
    rdy[0] = 1'b0;
    push_plain(0, 32'h7000, 4);
    cfg_wr(0, 0, 32'h7000); cfg_wr(0, 1, 4); cfg_wr(0, 2, 0);
    cfg_wr(0, 0, 32'h9000); cfg_wr(0, 1, 2); cfg_wr(0, 2, 0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(done[0] == 1'b0 && snk_valid[0] && mem_addr == 32'h7000, "R10",
        "busy channel kept its transfer", 160'(mem_addr), 160'h7000);
    @(posedge clk); #1 rdy[0] = 1'b1;
    drain();

    // R9 zero-count start
    cfg_wr(2, 1, 0); cfg_wr(2, 2, 0);
    @(negedge clk);
    chk(irq[2] && done[2] && snk_valid == '0, "R9", "zero count completes at once",
        {156'b0, irq[2], done[2], 2'b0}, 160'd12);
    @(negedge clk);
    chk(irq[2] == 1'b0, "R9", "irq is one cycle", 160'(irq[2]), '0);

    chk(exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size() == 0,
        "R2", "all expected quadwords delivered", '0, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule